// File: doc/BRIEF.md
# Byte-Serial Pipelined 64-bit Multiplier

This block multiplies two unsigned integers and returns the low half of their product. The operands and the result have the same width. The work is split across a chain of identical stages. Each stage takes one byte of the multiplier and multiplies it by a multiplicand that has already been shifted into the right weight. It then adds the result to a running sum that it receives from the stage before it. Between stages, the multiplier moves right by one byte and the multiplicand moves left by one byte. The next stage therefore always works on the lowest byte of its own multiplier.

A valid flag enters with each operand pair and moves through the chain in step with the data. The caller asserts `start_i` together with both operands in any clock cycle, with no gaps needed between pairs. `done_o` rises with the finished product a fixed number of cycles later, and results leave in the order they were issued. There is no stall. A synchronous active-low reset clears the valid flags everywhere in the chain. The data registers are not reset.

Top module: `mulpipe_top`

## Requirements
- R1: A rising clock edge at which `rst_n` is 0 clears every valid flag, so `done_o` reads 0 after that edge.
- R2: When `done_o` is 1, `prod_o` equals (multiplicand × multiplier) mod 2^64 for the operand pair that was issued.
- R3: The latency is exactly eight clock edges. A pair sampled with `start_i`=1 at edge n appears with `done_o`=1 after edge n+7, which is the eighth edge that samples it.
- R4: A new pair can be issued on every consecutive cycle. Each result appears once, in issue order, and none is lost or duplicated.
- R5: Operand values presented while `start_i`=0 produce no `done_o` pulse and do not disturb results that are already in flight.
- R6: Corner operands give exact results. Zero times any value gives 0, and all-ones times all-ones gives 1. Products whose set bits reach bit 63 are kept, and any bits above bit 63 are dropped.
- R7: A reset in the middle of a stream discards every operation in flight. No `done_o` pulse appears for them after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the valid chain |
| start_i | input | 1 | Marks the operand pair on this cycle as valid |
| mcnd_i | input | 64 | Multiplicand (unsigned) |
| mplr_i | input | 64 | Multiplier (unsigned), consumed one byte per stage from the low end |
| done_o | output | 1 | High for one cycle for each finished product |
| prod_o | output | 64 | Low 64 bits of the product, meaningful while `done_o` is 1 |

## Verification
Suppose one stage used the wrong byte, or shifted an operand by the wrong amount. Then `prod_o` would be wrong only for operands whose upper bytes are non-zero. The error would appear on the first such result, eight cycles after that pair was issued. This is why the random stream and the operands with high bits set matter more than small values. A fault in the valid chain shows in a different way: `done_o` pulses at the wrong cycle, pulses twice, or does not pulse at all. A reset that fails to flush shows as a pulse in the first eight cycles after release. The reference model compares `done_o` on every cycle, so a timing fault is caught at the first cycle where it differs.

// File: rtl/mulpipe_pkg.sv
// Package: shared defaults for the byte-serial multiplier.
// Assumes: operand width is a whole multiple of the digit width.
package mulpipe_pkg;
    localparam int unsigned DEF_DATA_W  = 64;
    localparam int unsigned DEF_DIGIT_W = 8;
endpackage

// File: rtl/mulpipe_digit.sv
// Module: mulpipe_digit
// Multiplies a DIGIT_W-bit digit by a DATA_W-bit multiplicand and keeps
// the low DATA_W bits. It is built from shift-and-add terms, one term per
// digit bit. Purely combinational.
// Assumes: DIGIT_W <= DATA_W.
module mulpipe_digit #(
    parameter int unsigned DATA_W  = mulpipe_pkg::DEF_DATA_W,
    parameter int unsigned DIGIT_W = mulpipe_pkg::DEF_DIGIT_W
) (
    input  logic [DIGIT_W-1:0] digit_i,
    input  logic [DATA_W-1:0]  mcnd_i,
    output logic [DATA_W-1:0]  pp_o
);
    // Add the multiplicand, shifted to each set digit bit's weight.
    always_comb begin
        pp_o = '0;
        for (int i = 0; i < int'(DIGIT_W); i++) begin
            if (digit_i[i]) begin
                pp_o = pp_o + (mcnd_i << i);
            end
        end
    end
endmodule

// File: rtl/mulpipe_opshift.sv
// Module: mulpipe_opshift
// Registers the operands for the next stage. The multiplier moves right by
// one digit and is zero-filled at the top. The multiplicand moves left by
// one digit and is zero-filled at the bottom.
// Assumes: data registers need no reset, because validity is tracked separately.
module mulpipe_opshift #(
    parameter int unsigned DATA_W  = mulpipe_pkg::DEF_DATA_W,
    parameter int unsigned DIGIT_W = mulpipe_pkg::DEF_DIGIT_W
) (
    input  logic              clk,
    input  logic [DATA_W-1:0] mplr_i,
    input  logic [DATA_W-1:0] mcnd_i,
    output logic [DATA_W-1:0] mplr_o,
    output logic [DATA_W-1:0] mcnd_o
);
    // Capture the shifted operands for the next stage.
    always_ff @(posedge clk) begin
        mplr_o <= mplr_i >> DIGIT_W;
        mcnd_o <= mcnd_i << DIGIT_W;
    end
endmodule

// File: rtl/mulpipe_stage.sv
// Module: mulpipe_stage
// One accumulation stage. It registers the incoming running sum and this
// stage's digit product, and presents their sum to the next stage. It also
// carries the valid flag, which a synchronous active-low reset clears.
// Assumes: digit and multiplicand arrive aligned with acc_i and go_i.
module mulpipe_stage #(
    parameter int unsigned DATA_W  = mulpipe_pkg::DEF_DATA_W,
    parameter int unsigned DIGIT_W = mulpipe_pkg::DEF_DIGIT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go_i,
    input  logic [DATA_W-1:0]  acc_i,
    input  logic [DIGIT_W-1:0] digit_i,
    input  logic [DATA_W-1:0]  mcnd_i,
    output logic               go_o,
    output logic [DATA_W-1:0]  acc_o
);
    logic [DATA_W-1:0] pp;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] pp_q;

    mulpipe_digit #(.DATA_W(DATA_W), .DIGIT_W(DIGIT_W)) u_digit (
        .digit_i (digit_i),
        .mcnd_i  (mcnd_i),
        .pp_o    (pp)
    );

    // Hold the running sum and this stage's digit product.
    always_ff @(posedge clk) begin
        acc_q <= acc_i;
        pp_q  <= pp;
    end

    // Valid flag: synchronously cleared, otherwise follows go_i.
    always_ff @(posedge clk) begin
        if (!rst_n) go_o <= 1'b0;
        else        go_o <= go_i;
    end

    // The next stage sees the updated running sum.
    assign acc_o = acc_q + pp_q;
endmodule

// File: rtl/mulpipe_top.sv
// Module: mulpipe_top
// Fully pipelined unsigned multiplier that returns the low DATA_W bits of the
// product, DATA_W/DIGIT_W stages after issue. It accepts one pair per cycle
// and has no stall.
// Assumes: DATA_W is a multiple of DIGIT_W.
module mulpipe_top #(
    parameter int unsigned DATA_W  = mulpipe_pkg::DEF_DATA_W,
    parameter int unsigned DIGIT_W = mulpipe_pkg::DEF_DIGIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] mcnd_i,
    input  logic [DATA_W-1:0] mplr_i,
    output logic              done_o,
    output logic [DATA_W-1:0] prod_o
);
    localparam int unsigned STAGES = DATA_W / DIGIT_W;

    logic              go_c   [0:STAGES];
    logic [DATA_W-1:0] acc_c  [0:STAGES];
    logic [DATA_W-1:0] mplr_c [0:STAGES-1];
    logic [DATA_W-1:0] mcnd_c [0:STAGES-1];

    assign go_c[0]   = start_i;
    assign acc_c[0]  = '0;
    assign mplr_c[0] = mplr_i;
    assign mcnd_c[0] = mcnd_i;

    for (genvar k = 0; k < int'(STAGES); k++) begin : g_stage
        mulpipe_stage #(.DATA_W(DATA_W), .DIGIT_W(DIGIT_W)) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .go_i    (go_c[k]),
            .acc_i   (acc_c[k]),
            .digit_i (mplr_c[k][DIGIT_W-1:0]),
            .mcnd_i  (mcnd_c[k]),
            .go_o    (go_c[k+1]),
            .acc_o   (acc_c[k+1])
        );
        if (k < int'(STAGES) - 1) begin : g_fwd
            mulpipe_opshift #(.DATA_W(DATA_W), .DIGIT_W(DIGIT_W)) u_shift (
                .clk    (clk),
                .mplr_i (mplr_c[k]),
                .mcnd_i (mcnd_c[k]),
                .mplr_o (mplr_c[k+1]),
                .mcnd_o (mcnd_c[k+1])
            );
        end
    end

    assign done_o = go_c[STAGES];
    assign prod_o = acc_c[STAGES];
endmodule

// File: rtl/mulpipe_chk.sv
// Module: mulpipe_chk
// Port-level checker for mulpipe_top. It keeps a short history of issued
// pairs and the products expected for them, and compares the outputs with
// that history. It is attached to every mulpipe_top through bind.
module mulpipe_chk #(
    parameter int unsigned DATA_W  = mulpipe_pkg::DEF_DATA_W,
    parameter int unsigned DIGIT_W = mulpipe_pkg::DEF_DIGIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] mcnd_i,
    input  logic [DATA_W-1:0] mplr_i,
    input  logic              done_o,
    input  logic [DATA_W-1:0] prod_o
);
    localparam int unsigned STAGES = DATA_W / DIGIT_W;

    logic [STAGES-1:0] seen_q;
    logic [STAGES-1:0] zero_q;
    logic [DATA_W-1:0] exp_q [0:STAGES-1];

    initial begin
        a_width_multiple: assert (DATA_W % DIGIT_W == 0)
            else $error("operand width is not a multiple of the digit width");
    end

    // History of issued flags, zero-operand markers and expected products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
            zero_q <= '0;
        end else begin
            seen_q <= {seen_q[STAGES-2:0], start_i};
            zero_q <= {zero_q[STAGES-2:0], (mcnd_i == '0) || (mplr_i == '0)};
        end
        exp_q[0] <= mcnd_i * mplr_i;
        for (int i = 1; i < int'(STAGES); i++) exp_q[i] <= exp_q[i-1];
    end

    // R1: a reset edge leaves done_o low.
    p_reset_clears_r1: assert property (@(posedge clk) !rst_n |=> !done_o);

    // R3 R5 R7: done_o follows start exactly STAGES edges later.
    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o == seen_q[STAGES-1]);

    // R2 R4: the product matches the pair issued STAGES edges earlier.
    p_product_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> prod_o == exp_q[STAGES-1]);

    // R6: a zero operand gives a zero result.
    p_zero_operand_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && zero_q[STAGES-1]) |-> prod_o == '0);
endmodule

bind mulpipe_top mulpipe_chk #(.DATA_W(DATA_W), .DIGIT_W(DIGIT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .mcnd_i  (mcnd_i),
    .mplr_i  (mplr_i),
    .done_o  (done_o),
    .prod_o  (prod_o)
);

// File: tb/test_mulpipe_top.sv
// Bench for mulpipe_top. A queue-based reference model predicts done_o and
// prod_o for every cycle, and the bench compares them at each falling edge.
module test_mulpipe_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] ma = '0;
    logic [63:0] mb = '0;
    logic        done;
    logic [63:0] prod;

    int    checks = 0;
    int    errors = 0;
    string phase  = "R1";

    typedef struct {
        bit          v;
        logic [63:0] p;
        string       tag;
    } ent_t;
    ent_t q[$];

    always #4 clk = ~clk;

    mulpipe_top i_mulpipe_top (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .mcnd_i  (ma),
        .mplr_i  (mb),
        .done_o  (done),
        .prod_o  (prod)
    );

    // Drive one cycle at a falling edge, update the model, compare at the next falling edge.
    task automatic step(bit s, logic [63:0] a, logic [63:0] b, string tag);
        ent_t  e;
        bit    ev;
        string et;
        start = s;
        ma    = a;
        mb    = b;
        e.v   = s && rst_n;
        e.p   = a * b;
        e.tag = tag;
        if (!rst_n) begin
            foreach (q[i]) q[i].v = 1'b0;
        end
        q.push_back(e);
        if (q.size() > 8) void'(q.pop_front());
        @(negedge clk);
        ev = (q.size() == 8) ? q[0].v : 1'b0;
        et = ev ? q[0].tag : phase;
        checks++;
        if (done !== ev) begin
            errors++;
            $display("FAIL %s done: actual=%b expected=%b", et, done, ev);
        end
        if (ev) begin
            checks++;
            if (prod !== q[0].p) begin
                errors++;
                $display("FAIL %s product: actual=%h expected=%h", et, prod, q[0].p);
            end
        end
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: done stays low while reset is held.
        phase = "R1";
        for (int i = 0; i < 4; i++) step(1'b1, rnd64(), rnd64(), "R1");
        rst_n = 1'b1;
        // R3: one operation, then idle, so its exact cycle is checked.
        phase = "R3";
        step(1'b1, 64'h0123_4567_89ab_cdef, 64'hfedc_ba98_7654_3210, "R3");
        for (int i = 0; i < 10; i++) step(1'b0, '0, '0, "R3");
        // R2: random operands, issued on alternate cycles.
        phase = "R2";
        for (int i = 0; i < 60; i++) step(i % 2 == 0, rnd64(), rnd64(), "R2");
        // R4: back-to-back issue on every cycle.
        phase = "R4";
        for (int i = 0; i < 80; i++) step(1'b1, rnd64(), rnd64(), "R4");
        // R6: corner operands.
        phase = "R6";
        step(1'b1, '0, rnd64(), "R6");
        step(1'b1, rnd64(), '0, "R6");
        step(1'b1, '1, '1, "R6");
        step(1'b1, '1, 64'd1, "R6");
        step(1'b1, 64'h8000_0000_0000_0000, 64'd2, "R6");
        step(1'b1, 64'd256, 64'h0100_0000_0000_0000, "R6");
        step(1'b1, 64'hff, 64'hff00_0000_0000_0000, "R6");
        step(1'b1, '1, 64'h8000_0000_0000_0001, "R6");
        // R5: operand changes with start low, mixed with valid ops in flight.
        phase = "R5";
        for (int i = 0; i < 30; i++) step(i % 7 == 0, rnd64(), rnd64(), "R5");
        for (int i = 0; i < 10; i++) step(1'b0, rnd64(), rnd64(), "R5");
        // R7: a reset in the middle of a stream discards in-flight work.
        phase = "R7";
        for (int i = 0; i < 5; i++) step(1'b1, rnd64(), rnd64(), "R7");
        rst_n = 1'b0;
        step(1'b1, rnd64(), rnd64(), "R7");
        rst_n = 1'b1;
        for (int i = 0; i < 12; i++) step(1'b0, rnd64(), rnd64(), "R7");
        step(1'b1, 64'd3, 64'd5, "R7");
        for (int i = 0; i < 10; i++) step(1'b0, '0, '0, "R7");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule